// File: doc/BRIEF.md
# Sequence-Guarded Watchdog Timer

This block is a watchdog timer driven by a slow tick strobe, meant to sit on a simple word-addressed register bus. A free-running up-counter advances on the tick, optionally slowed by a power-of-two prescaler. When it wraps past all ones while running, the block raises a one-clock reset request and reloads itself from the load register. Software keeps the system alive by writing the trigger register with a value different from the last one it wrote, which reloads the counter.

The counter can only be started or stopped by writing two specific 16-bit keys, in order, to the run-control register. Every writable register is a posted write with its own pending flag. A write to a register that still has a pending write is dropped, so software polls the status register before writing that register again. A write takes effect, and its pending flag clears, on the second tick strobe after the bus write. Reads are combinational from the address.

Top module: `wdt_seq_guard`

## Requirements
- R1: After reset the counter is running from count 0. The load register, control register, counter and status register all read 0, and the reset request is low.
- R2: The run-control register (address 5) starts the counter only after the key 0xBBBB and then the key 0x4444 have both taken effect, in that order. The count is held across the start edge.
- R3: The run-control register stops the counter only after the key 0xAAAA and then the key 0x5555 have both taken effect, in that order. Once stopped, the count does not change on ticks.
- R4: If any word other than the expected second key takes effect after a first key, the detector returns to idle and the run state is unchanged. A later lone second key then does nothing.
- R5: The status register (address 6) sets a pending bit in the cycle after a write is accepted: bit 0 for control, bit 2 for load, bit 3 for trigger, bit 4 for run-control. The bit clears on the second tick after the write, which is the edge on which the write takes effect.
- R6: A write to a register whose pending bit is set is ignored. The earlier value is the one that takes effect.
- R7: A trigger (address 4) reloads the counter from the load register (address 2) only if its 16-bit data differs from the previous trigger data. The previous trigger data resets to 0.
- R8: With the prescaler disabled and the counter running, the counter (address 3) increments by one on every tick.
- R9: Control register (address 1) bit 5 enables the prescaler and bits 4:2 hold the ratio r. When the prescaler is enabled, the counter advances once every 2^r ticks, counted from the edge on which the control write took effect.
- R10: When the counter is all ones and advances while running, the counter reloads from the load register. The reset request goes high for exactly one clock, in the cycle after that tick edge.
- R11: Address 0 reads a fixed revision code in bits 7:0, which is 0x5A by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW (3) | Word address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| tick_en | input | 1 | One-clock strobe at the slow tick rate |
| rst_req | output | 1 | One-clock reset request on counter wrap |

## Verification
The hardest case to reach is the wrap at all ones. It needs a counter that is running, with the prescaler off and a known load value. Those conditions can only be set up through posted writes whose own ticks also move the counter. The bench builds the design with an 8-bit counter. It commits a load value of 0xF0 and reloads it with a fresh trigger pattern, which overrides the tick advance on that edge. It then counts exactly fifteen ticks to 0xFF, so the sixteenth tick must wrap. The prescaler sweep covers every ratio and reads the counter just before and just after each expected advance.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int A_REV  = 0;
  localparam int A_CTRL = 1;
  localparam int A_LOAD = 2;
  localparam int A_CNT  = 3;
  localparam int A_TRIG = 4;
  localparam int A_RUN  = 5;
  localparam int A_STAT = 6;

  localparam int SB_CTRL = 0;
  localparam int SB_LOAD = 2;
  localparam int SB_TRIG = 3;
  localparam int SB_RUN  = 4;

  localparam logic [15:0] KEY_ON1  = 16'hBBBB;
  localparam logic [15:0] KEY_ON2  = 16'h4444;
  localparam logic [15:0] KEY_OFF1 = 16'hAAAA;
  localparam logic [15:0] KEY_OFF2 = 16'h5555;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_ARM_ON = 2'd1,
    SQ_ARM_OFF = 2'd2
  } seq_state_t;
endpackage

// File: rtl/wdt_post_slot.sv
module wdt_post_slot #(
  parameter int W   = 16,
  parameter int LAT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic         pend,
  output logic         commit,
  output logic [W-1:0] data
);
  localparam int TW = $clog2(LAT + 1);
  logic [TW-1:0] tcnt;

  assign commit = pend && tick && (tcnt == TW'(LAT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      tcnt <= '0;
      data <= '0;
    end else if (wr && !pend) begin
      pend <= 1'b1;
      tcnt <= '0;
      data <= wdata;
    end else if (commit) begin
      pend <= 1'b0;
    end else if (pend && tick) begin
      tcnt <= tcnt + 1'b1;
    end
  end

  assert_pend_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !commit |=> pend);
  assert_pend_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(wr));
  assert_drop_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !commit |=> $stable(data));
endmodule

// File: rtl/wdt_seq_det.sv
module wdt_seq_det #(
  parameter bit RUN_AT_RESET = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        commit,
  input  logic [15:0] word,
  output logic        run
);
  import wdt_pkg::*;
  seq_state_t st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= SQ_IDLE;
      run <= RUN_AT_RESET;
    end else if (commit) begin
      unique case (st)
        SQ_IDLE: begin
          if (word == KEY_ON1)       st <= SQ_ARM_ON;
          else if (word == KEY_OFF1) st <= SQ_ARM_OFF;
        end
        SQ_ARM_ON: begin
          st <= SQ_IDLE;
          if (word == KEY_ON2) run <= 1'b1;
        end
        SQ_ARM_OFF: begin
          st <= SQ_IDLE;
          if (word == KEY_OFF2) run <= 1'b0;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assert_start_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(st) == SQ_ARM_ON);
  assert_stop_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> $past(st) == SQ_ARM_OFF);
  assert_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(run) |-> $past(commit));
endmodule

// File: rtl/wdt_tick_div.sv
module wdt_tick_div #(
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic [RW-1:0] ratio,
  input  logic          clr,
  output logic          adv
);
  localparam int PW = (1 << RW) - 1;
  logic [PW-1:0] pcnt;
  logic [PW-1:0] mask;

  assign mask = ~({PW{1'b1}} << ratio);
  assign adv  = tick && (!en || (pcnt >= mask));

  always_ff @(posedge clk) begin
    if (!rst_n || clr || !en) pcnt <= '0;
    else if (tick) pcnt <= (pcnt >= mask) ? '0 : pcnt + 1'b1;
  end

  assert_adv_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> tick);
  assert_div_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    en && !clr |-> pcnt <= mask || $past(clr) || !$past(en) || $changed(ratio));
endmodule

// File: rtl/wdt_seq_guard.sv
module wdt_seq_guard #(
  parameter int         AW           = 3,
  parameter int         CNT_W        = 32,
  parameter int         RATIO_W      = 3,
  parameter int         POST_LAT     = 2,
  parameter logic [7:0] REV_CODE     = 8'h5A,
  parameter bit         RUN_AT_RESET = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          tick_en,
  output logic          rst_req
);
  import wdt_pkg::*;
  localparam int CW = RATIO_W + 1;

  logic wr_ctrl, wr_load, wr_trig, wr_run;
  assign wr_ctrl = bus_we && (bus_addr == AW'(A_CTRL));
  assign wr_load = bus_we && (bus_addr == AW'(A_LOAD));
  assign wr_trig = bus_we && (bus_addr == AW'(A_TRIG));
  assign wr_run  = bus_we && (bus_addr == AW'(A_RUN));

  logic pd_ctrl, pd_load, pd_trig, pd_run;
  logic cm_ctrl, cm_load, cm_trig, cm_run;
  logic [CW-1:0]    sh_ctrl;
  logic [CNT_W-1:0] sh_load;
  logic [15:0]      sh_trig, sh_run;

  wdt_post_slot #(.W(CW), .LAT(POST_LAT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .wr(wr_ctrl),
    .wdata(bus_wdata[CW+1:2]), .pend(pd_ctrl), .commit(cm_ctrl), .data(sh_ctrl));
  wdt_post_slot #(.W(CNT_W), .LAT(POST_LAT)) u_load (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .wr(wr_load),
    .wdata(bus_wdata[CNT_W-1:0]), .pend(pd_load), .commit(cm_load), .data(sh_load));
  wdt_post_slot #(.W(16), .LAT(POST_LAT)) u_trig (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .wr(wr_trig),
    .wdata(bus_wdata[15:0]), .pend(pd_trig), .commit(cm_trig), .data(sh_trig));
  wdt_post_slot #(.W(16), .LAT(POST_LAT)) u_run (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .wr(wr_run),
    .wdata(bus_wdata[15:0]), .pend(pd_run), .commit(cm_run), .data(sh_run));

  logic [CW-1:0]    ctrl_q;
  logic [CNT_W-1:0] load_q;
  logic [15:0]      trig_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      load_q    <= '0;
      trig_last <= '0;
    end else begin
      if (cm_ctrl) ctrl_q <= sh_ctrl;
      if (cm_load) load_q <= sh_load;
      if (cm_trig) trig_last <= sh_trig;
    end
  end

  logic run;
  wdt_seq_det #(.RUN_AT_RESET(RUN_AT_RESET)) u_seq (
    .clk(clk), .rst_n(rst_n), .commit(cm_run), .word(sh_run), .run(run));

  logic div_adv;
  wdt_tick_div #(.RW(RATIO_W)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .en(ctrl_q[CW-1]),
    .ratio(ctrl_q[RATIO_W-1:0]), .clr(!run || cm_ctrl), .adv(div_adv));

  logic [CNT_W-1:0] cnt;
  logic adv, trig_hit, wrap;
  assign adv      = run && div_adv;
  assign trig_hit = cm_trig && (sh_trig != trig_last);
  assign wrap     = adv && (&cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= wrap && !trig_hit;
      if (trig_hit)  cnt <= load_q;
      else if (wrap) cnt <= load_q;
      else if (adv)  cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(A_REV):  bus_rdata[7:0] = REV_CODE;
      AW'(A_CTRL): bus_rdata[CW+1:2] = ctrl_q;
      AW'(A_LOAD): bus_rdata = 32'(load_q);
      AW'(A_CNT):  bus_rdata = 32'(cnt);
      AW'(A_STAT): begin
        bus_rdata[SB_CTRL] = pd_ctrl;
        bus_rdata[SB_LOAD] = pd_load;
        bus_rdata[SB_TRIG] = pd_trig;
        bus_rdata[SB_RUN]  = pd_run;
      end
      default: bus_rdata = '0;
    endcase
  end

  assert_rst_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  assert_rst_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> cnt == $past(load_q) && $past(run));
  assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !trig_hit |=> $stable(cnt));
  assert_trig_same_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cm_trig && sh_trig == trig_last && !run |=> $stable(cnt));
endmodule

// File: tb/tb_wdt_seq_guard.sv
module tb_wdt_seq_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic tick_en = 1'b0;
  logic rst_req;
  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  wdt_seq_guard #(.AW(3), .CNT_W(8), .RATIO_W(3), .POST_LAT(2),
                  .REV_CODE(8'h5A), .RUN_AT_RESET(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
    .rst_req(rst_req));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic chk_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic tk();
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic post(input logic [2:0] a, input logic [31:0] d);
    wr(a, d); tk(); tk();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R11 revision
    chk_reg("R11", 3'd0, 32'h5A);
    chk_reg("R1 ctrl", 3'd1, 0);
    chk_reg("R1 load", 3'd2, 0);
    chk_reg("R1 cnt", 3'd3, 0);
    chk_reg("R1 stat", 3'd6, 0);
    chk("R1 rst_req", 32'(rst_req), 0);
    // R3 stop: running from 0, four ticks pass including the stop commit edge
    post(3'd5, 32'hAAAA);
    post(3'd5, 32'h5555);
    chk_reg("R3 stop count", 3'd3, 4);
    repeat (5) tk();
    chk_reg("R3 held", 3'd3, 4);
    // R5 pending bits per register
    wr(3'd1, 32'h0);      chk_reg("R5 ctrl set", 3'd6, 32'h01);
    tk();                 chk_reg("R5 ctrl one tick", 3'd6, 32'h01);
    tk();                 chk_reg("R5 ctrl clear", 3'd6, 0);
    wr(3'd2, 32'h40);     chk_reg("R5 load set", 3'd6, 32'h04);
    tk(); tk();           chk_reg("R5 load clear", 3'd6, 0);
    chk_reg("R5 load value", 3'd2, 32'h40);
    wr(3'd4, 32'h11);     chk_reg("R5 trig set", 3'd6, 32'h08);
    tk(); tk();           chk_reg("R5 trig clear", 3'd6, 0);
    chk_reg("R7 reload on new pattern", 3'd3, 32'h40);
    wr(3'd5, 32'h0);      chk_reg("R5 run set", 3'd6, 32'h10);
    tk(); tk();           chk_reg("R5 run clear", 3'd6, 0);
    // R6 second write while pending is dropped
    wr(3'd2, 32'h50);
    wr(3'd2, 32'h60);
    tk(); tk();
    chk_reg("R6 load keeps first", 3'd2, 32'h50);
    // R7 repeat pattern does not reload, new one does
    post(3'd4, 32'h11);
    chk_reg("R7 same pattern", 3'd3, 32'h40);
    post(3'd4, 32'h22);
    chk_reg("R7 new pattern", 3'd3, 32'h50);
    // R4 broken start sequence
    post(3'd5, 32'hBBBB);
    post(3'd5, 32'h1234);
    post(3'd5, 32'h4444);
    repeat (4) tk();
    chk_reg("R4 still stopped", 3'd3, 32'h50);
    // R2 start, with R6 dropped second key during pending
    wr(3'd5, 32'hBBBB);
    wr(3'd5, 32'h4444);
    tk(); tk();
    chk_reg("R6 run pending dropped", 3'd3, 32'h50);
    post(3'd5, 32'h4444);
    chk_reg("R2 start count held", 3'd3, 32'h50);
    // R8 one step per tick
    for (int i = 1; i <= 10; i++) begin
      tk();
      chk_reg("R8 tick step", 3'd3, 32'h50 + i);
    end
    // R9 prescaler sweep over every ratio
    for (int r = 0; r < 8; r++) begin
      post(3'd1, 32'h20 | (r << 2));
      chk_reg("R9 ctrl readback", 3'd1, 32'h20 | (r << 2));
      rd(3'd3, c0);
      repeat (3 * (1 << r) - 1) tk();
      chk_reg("R9 before advance", 3'd3, c0 + 2);
      tk();
      chk_reg("R9 at advance", 3'd3, c0 + 3);
    end
    post(3'd1, 32'h0);
    // R10 wrap
    post(3'd2, 32'hF0);
    post(3'd4, 32'h33);
    chk_reg("R10 reloaded", 3'd3, 32'hF0);
    repeat (15) tk();
    chk_reg("R10 at top", 3'd3, 32'hFF);
    chk("R10 no request yet", 32'(rst_req), 0);
    tk();
    chk("R10 request", 32'(rst_req), 1);
    chk_reg("R10 wrap reload", 3'd3, 32'hF0);
    @(negedge clk);
    chk("R10 one clock", 32'(rst_req), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule